// File: doc/BRIEF.md
# March-Test Memory Self-Test Sequencer

This block tests an embedded single-port RAM that holds one word per address. It drives the RAM on its own and runs one of three march algorithms: a zero-one scan, MATS+, or a checkerboard scan. Each algorithm is a fixed series of march elements. An element visits every address in ascending or descending order. At each address it applies a short list of write and read operations before it moves on.

Every read is compared against the word the algorithm expects. The RAM returns read data one cycle after the address, so the compare runs one cycle behind the issue. The first mismatch is held together with its address and element index. The run always goes on to the last operation, and then a one-cycle done pulse marks the end of the test.

Top module: `mbist_march`

## Requirements
- R1: While reset is held and after it is released, `done`, `fail`, `mem_en` and `mem_we` are low and `fail_addr` and `fail_elem` are zero.
- R2: Algorithm code 0 (and code 3, which behaves the same) runs four ascending elements: write all-zeros, read all-zeros, write all-ones, read all-ones. This is exactly 4N RAM operations for N = 2^ADDR_W words. Every written word is all-zeros or all-ones.
- R3: Algorithm code 1 runs three elements in 5N operations:
  - element 0 writes all-zeros in ascending order;
  - element 1 goes upward, reading all-zeros and then writing all-ones at each address;
  - element 2 goes downward from N-1 to 0, reading all-ones and then writing all-zeros.
- R4: Algorithm code 2 runs four ascending elements in 4N operations. Colour is `addr[0] ^ addr[COL_W]`. Element 0 writes all-ones to colour-1 cells and all-zeros to colour-0 cells, and element 1 reads that pattern back. Element 2 writes the inverse pattern, and element 3 reads it back.
- R5: The bench samples `mem_rdata` in the cycle after a read is issued and compares the whole word with the expected word. A difference in any single bit is a mismatch.
- R6: The first mismatch sets `fail` and stores its address in `fail_addr` and its element index (0-based) in `fail_elem`. Later mismatches change none of the three, and the run still performs its full operation count.
- R7: `done` is high for exactly one cycle, two cycles after the cycle of the last RAM operation. No RAM access happens while `done` is high.
- R8: A `start` sampled while the block is idle begins a run and clears `fail`, `fail_addr` and `fail_elem` at that edge. A `start` seen while a run is in progress is ignored.
- R9: A fault-free RAM gives `fail` low at `done` for every algorithm, and `mem_we` is only ever high together with `mem_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| alg_sel | input | 2 | Algorithm: 0 scan, 1 MATS+, 2 checkerboard, 3 scan |
| mem_en | output | 1 | RAM access this cycle |
| mem_we | output | 1 | RAM write (read when low with mem_en) |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write word |
| mem_rdata | input | DATA_W | RAM read word, valid one cycle after a read |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | A mismatch was seen in this run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 2 | Element index of the first mismatch |

## Verification
The bench builds the block with ADDR_W=4, DATA_W=8 and COL_W=2. A 16-word RAM keeps every run under a hundred cycles and lets the bench work out by hand, for each algorithm, which element first sees each fault:
- a stuck-at-0 bit at address 5 (colour 0);
- a stuck-at-1 bit at address 9 (colour 1);
- a transition coupling from address 2 onto address 12.

With COL_W=2, bit 2 of the address decides the row parity, so both colours appear within the first four words. The coupling fault escapes the scan and checkerboard runs but is caught by MATS+. The combined fault shows that the first-failure record holds when a later element mismatches again.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        ALG_SCAN = 2'd0,
        ALG_MATS = 2'd1,
        ALG_CHK  = 2'd2,
        ALG_ALT  = 2'd3
    } alg_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } seq_st_e;

    // one operation: read or write, and the data polarity it uses
    typedef struct packed {
        logic rd;
        logic pol;
    } op_t;

    // one march element: direction, one or two operations
    typedef struct packed {
        logic down;
        logic two;
        op_t  op0;
        op_t  op1;
    } elem_t;

    function automatic elem_t elem_desc(alg_e alg, logic [1:0] idx);
        elem_t e;
        e.down    = 1'b0;
        e.two     = 1'b0;
        e.op0.rd  = 1'b0;
        e.op0.pol = 1'b0;
        e.op1.rd  = 1'b0;
        e.op1.pol = 1'b0;
        if (alg == ALG_MATS) begin
            case (idx)
                2'd1: begin
                    e.two     = 1'b1;
                    e.op0.rd  = 1'b1;
                    e.op1.pol = 1'b1;
                end
                2'd2: begin
                    e.down    = 1'b1;
                    e.two     = 1'b1;
                    e.op0.rd  = 1'b1;
                    e.op0.pol = 1'b1;
                end
                default: ;
            endcase
        end else begin
            // scan and checkerboard share the element list; polarity differs per cell in checkerboard
            e.op0.rd  = idx[0];
            e.op0.pol = idx[1];
        end
        return e;
    endfunction

    function automatic logic [1:0] last_elem(alg_e alg);
        return (alg == ALG_MATS) ? 2'd2 : 2'd3;
    endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int COL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        alg_sel,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_exp,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_elem,
    output logic              clr,
    output logic              done
);

    localparam logic [ADDR_W-1:0] A_ONE = 1;
    localparam logic [ADDR_W-1:0] A_MAX = '1;

    typedef struct packed {
        seq_st_e           st;
        alg_e              alg;
        logic [1:0]        elem;
        logic [ADDR_W-1:0] addr;
        logic              opi;
    } seq_t;

    seq_t  s_d, s_q;
    elem_t el, el_nx;
    op_t   op;
    logic  colour, bitv, last_op, last_addr;

    always_comb begin
        s_d       = s_q;
        clr       = 1'b0;
        el        = elem_desc(s_q.alg, s_q.elem);
        el_nx     = elem_desc(s_q.alg, s_q.elem + 2'd1);
        op        = s_q.opi ? el.op1 : el.op0;
        colour    = s_q.addr[0] ^ s_q.addr[COL_W];
        bitv      = (s_q.alg == ALG_CHK) ? (colour ^ op.pol) : op.pol;
        last_op   = !el.two || s_q.opi;
        last_addr = el.down ? (s_q.addr == '0) : (s_q.addr == A_MAX);

        mem_en    = (s_q.st == ST_RUN);
        mem_we    = mem_en && !op.rd;
        mem_addr  = s_q.addr;
        mem_wdata = {DATA_W{bitv}};
        rd_vld    = mem_en && op.rd;
        rd_exp    = {DATA_W{bitv}};
        rd_addr   = s_q.addr;
        rd_elem   = s_q.elem;
        done      = (s_q.st == ST_DONE);

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    clr      = 1'b1;
                    s_d.st   = ST_RUN;
                    s_d.alg  = alg_e'(alg_sel);
                    s_d.elem = 2'd0;
                    s_d.addr = '0;      // element 0 ascends in every algorithm
                    s_d.opi  = 1'b0;
                end
            end
            ST_RUN: begin
                if (!last_op) begin
                    s_d.opi = 1'b1;
                end else begin
                    s_d.opi = 1'b0;
                    if (last_addr) begin
                        if (s_q.elem == last_elem(s_q.alg)) begin
                            s_d.st = ST_FLUSH;
                        end else begin
                            s_d.elem = s_q.elem + 2'd1;
                            s_d.addr = el_nx.down ? A_MAX : '0;
                        end
                    end else begin
                        s_d.addr = el.down ? (s_q.addr - A_ONE) : (s_q.addr + A_ONE);
                    end
                end
            end
            ST_FLUSH: s_d.st = ST_DONE;
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, alg: ALG_SCAN, elem: 2'd0, addr: '0, opi: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd_vld,
    input  logic [DATA_W-1:0] rd_exp,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_elem,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [1:0]        fail_elem
);

    typedef struct packed {
        logic              pv;
        logic [DATA_W-1:0] pexp;
        logic [ADDR_W-1:0] paddr;
        logic [1:0]        pelem;
        logic              fail;
        logic [ADDR_W-1:0] faddr;
        logic [1:0]        felem;
    } cmp_t;

    cmp_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        // one-cycle pipeline: the read issued now is compared next cycle
        c_d.pv    = rd_vld;
        c_d.pexp  = rd_exp;
        c_d.paddr = rd_addr;
        c_d.pelem = rd_elem;
        if (clr) begin
            c_d.fail  = 1'b0;
            c_d.faddr = '0;
            c_d.felem = 2'd0;
        end else if (c_q.pv && (mem_rdata != c_q.pexp) && !c_q.fail) begin
            c_d.fail  = 1'b1;
            c_d.faddr = c_q.paddr;
            c_d.felem = c_q.pelem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign fail      = c_q.fail;
    assign fail_addr = c_q.faddr;
    assign fail_elem = c_q.felem;

endmodule

// File: rtl/mbist_march.sv
module mbist_march
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int COL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        alg_sel,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [1:0]        fail_elem
);

    logic              rd_vld, clr;
    logic [DATA_W-1:0] rd_exp;
    logic [ADDR_W-1:0] rd_addr;
    logic [1:0]        rd_elem;

    mbist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .alg_sel   (alg_sel),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rd_vld    (rd_vld),
        .rd_exp    (rd_exp),
        .rd_addr   (rd_addr),
        .rd_elem   (rd_elem),
        .clr       (clr),
        .done      (done)
    );

    mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .rd_vld    (rd_vld),
        .rd_exp    (rd_exp),
        .rd_addr   (rd_addr),
        .rd_elem   (rd_elem),
        .mem_rdata (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_elem (fail_elem)
    );

endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_en,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [1:0]        fail_elem
);

    assert_we_with_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_access_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_en);

    assert_uniform_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == '0 || mem_wdata == '1));

    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    assert_fail_record_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> ($stable(fail_addr) && $stable(fail_elem)));

    assert_fail_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(mem_en && !mem_we, 2));

endmodule

bind mbist_march mbist_march_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem)
);

// File: tb/tb_mbist_march.sv
`timescale 1ns/1ps
module tb_mbist_march;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int CW = 2;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    alg_sel = 2'd0;
    logic          mem_en, mem_we, done, fail;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [1:0]    fail_elem;

    always #2.5 clk = ~clk;

    mbist_march #(.ADDR_W(AW), .DATA_W(DW), .COL_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
        .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem)
    );

    int checks = 0;
    int fails  = 0;

    // RAM model with fault injection
    logic          clr = 1'b0;
    logic          sa_en = 1'b0, sa_val = 1'b0, cf_en = 1'b0;
    logic [DW-1:0] ram [N];
    int            ops_cnt = 0, wr_cnt = 0, wr_bad = 0;
    logic [AW-1:0] alog [128];

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < N; i++) ram[i] <= '0;
            ops_cnt <= 0;
            wr_cnt  <= 0;
            wr_bad  <= 0;
        end else if (mem_en) begin
            alog[ops_cnt[6:0]] <= mem_addr;
            ops_cnt <= ops_cnt + 1;
            if (mem_we) begin
                logic [DW-1:0] w;
                w = mem_wdata;
                // stuck-at-0: address 5 bit 3; stuck-at-1: address 9 bit 0
                if (sa_en && !sa_val && mem_addr == 4'd5) w[3] = 1'b0;
                if (sa_en &&  sa_val && mem_addr == 4'd9) w[0] = 1'b1;
                ram[mem_addr] <= w;
                // coupling: a bit-0 transition at address 2 inverts bit 0 of address 12
                if (cf_en && mem_addr == 4'd2 && w[0] != ram[2][0])
                    ram[12][0] <= ~ram[12][0];
                if (alg_sel == 2'd2) begin
                    if (mem_wdata != {DW{(mem_addr[0] ^ mem_addr[CW]) ^ (wr_cnt >= N)}})
                        wr_bad <= wr_bad + 1;
                    wr_cnt <= wr_cnt + 1;
                end
            end else begin
                mem_rdata <= ram[mem_addr];
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0] alg;
        logic       sa_en;
        logic       sa_val;
        logic       cf_en;
        logic       exp_fail;
        logic [3:0] exp_addr;
        logic [1:0] exp_elem;
        logic [7:0] exp_ops;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 8'd64},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 8'd80},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 8'd64},
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5,  2'd3, 8'd64},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5,  2'd2, 8'd80},
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5,  2'd3, 8'd64},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd9,  2'd1, 8'd64},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd9,  2'd1, 8'd80},
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 4'd9,  2'd3, 8'd64},
        '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  2'd0, 8'd64},
        '{2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd12, 2'd1, 8'd80},
        '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  2'd0, 8'd64},
        '{2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd12, 2'd1, 8'd80},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 8'd64}
    };

    // runs one algorithm; inj pulses start with another code mid-run
    task automatic run_alg(input logic [1:0] a, input bit inj,
                           output int lat, output logic early_fail);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        alg_sel = a;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        early_fail = fail;
        lat = 0;
        while (!done && lat < 2000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (inj && lat == 10) begin
                start = 1'b1;
                alg_sel = 2'd0;
            end else begin
                start = 1'b0;
                alg_sel = a;
            end
        end
        if (lat >= 2000) check(1'b0, "R7", "watchdog on done", lat, 0);
    endtask

    initial begin
        #750000;
        fails++;
        $display("FAIL R7 watchdog expired: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int   lat;
        logic ef;
        string rq;

        repeat (3) @(negedge clk);
        check(!done && !fail && !mem_en && !mem_we, "R1", "outputs in reset",
              {done, fail, mem_en, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fail_addr == 0 && fail_elem == 0 && !done && !mem_en, "R1",
              "outputs after reset", {fail_addr, fail_elem}, 0);

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            sa_en  = t.sa_en;
            sa_val = t.sa_val;
            cf_en  = t.cf_en;
            run_alg(t.alg, 1'b0, lat, ef);
            rq = (t.alg == 2'd1) ? "R3" : (t.alg == 2'd2) ? "R4" : "R2";
            check(ef == 1'b0, "R8", "fail cleared on start", ef, 0);
            check(fail == t.exp_fail, t.exp_fail ? "R5" : "R9", "fail flag", fail, t.exp_fail);
            if (t.exp_fail) begin
                check(fail_addr == t.exp_addr, "R6", "fail address", fail_addr, t.exp_addr);
                check(fail_elem == t.exp_elem, "R6", "fail element", fail_elem, t.exp_elem);
            end
            check(ops_cnt == t.exp_ops, rq, "operation count", ops_cnt, t.exp_ops);
            check(lat == ops_cnt + 1, "R7", "done latency", lat, ops_cnt + 1);
            if (t.alg == 2'd2)
                check(wr_bad == 0 && wr_cnt == 2 * N, "R4", "checkerboard write words",
                      wr_bad, 0);
            if (t.alg == 2'd1 && !t.sa_en && !t.cf_en) begin
                check(alog[16] == 0,  "R3", "element 1 first address", alog[16], 0);
                check(alog[48] == 15, "R3", "element 2 first address", alog[48], 15);
                check(alog[50] == 14, "R3", "element 2 descends", alog[50], 14);
                check(alog[79] == 0,  "R3", "element 2 last address", alog[79], 0);
            end
            if (t.alg == 2'd0 && !t.sa_en && !t.cf_en)
                check(alog[63] == 15, "R2", "last scan address ascends", alog[63], 15);
            @(posedge clk);
            @(negedge clk);
            check(!done, "R7", "done one cycle wide", done, 0);
        end

        // start during a run is ignored
        sa_en  = 1'b1;
        sa_val = 1'b0;
        cf_en  = 1'b1;
        run_alg(2'd1, 1'b1, lat, ef);
        check(ops_cnt == 80, "R8", "ops with ignored start", ops_cnt, 80);
        check(fail && fail_addr == 12 && fail_elem == 1, "R8", "result with ignored start",
              {fail, fail_addr, fail_elem}, {1'b1, 4'd12, 2'd1});

        // results persist while idle
        repeat (5) @(negedge clk);
        check(fail && fail_addr == 12 && !mem_en, "R6", "record held while idle",
              {fail, fail_addr}, {1'b1, 4'd12});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule